// File: doc/BRIEF.md
# Arm/Fire Deployment Sequencer

This block controls eight squib output channels organised as four pairs, with one firing-enable group per pair. The command decoder upstream hands it one strobe per 16-bit command. Each strobe carries an opcode, an 8-bit channel mask and a flag that says whether parity was good. A deployment needs two commands in a row: an arm command, then a fire command. Only the channels named in both masks are started.

Once a channel is started it opens a wait window, one firing period long, and raises its status flag. The group enable may arrive at any point in that window. When it does, the channel drives its high-side and low-side outputs together for one full firing period. At the end of the drive the channel raises a sticky success flag. That flag blocks any further deployment of the channel until software clears it with a mask. Each channel has a 2-bit profile code that picks its firing period from four parameters given in clock cycles.

While any channel is driving, the block ignores commands, the external reset request and the soft reset, and flags each ignored command. A fault abort and the asynchronous power reset stop everything at once.

Top module: `deploy_seq`

## Requirements
- R1: A valid fire command (opcode 2) that comes directly after a valid arm command (opcode 1) starts only the channels set in both the arm mask and the fire mask. The status of each started channel rises on the edge that samples the fire command.
- R2: Any other accepted command between the arm and the fire cancels the arm. This includes opcode 0, a clear, or a command with bad parity.
- R3: A valid fire command that arrives with no pending arm starts nothing. It raises fire_err for exactly one cycle, on the edge that samples it.
- R4: A command with cmd_par_ok low is discarded and cancels any pending arm. It changes no channel and raises no error.
- R5: A valid arm command raises diag_stop for one cycle, on the edge that samples it.
- R6: A started channel waits up to one period for its group enable, with its drive outputs off. If the enable never comes, status falls after one period and success stays 0. If the enable comes, the outputs drive for exactly one full period.
- R7: Channel i is enabled only by en_grp[i/2].
- R8: Status stays high from the start of a channel until the end of its drive. Success rises on the edge where the drive ends and stays high until a clear command (opcode 3) names that channel's bit in cmd_mask.
- R9: A channel whose success flag is set does not start again.
- R10: While any channel is driving, these have no effect: commands (each one raises cmd_ignored for one cycle), pin_reset, soft_reset, and a drop of the enable. When no channel is driving, pin_reset and soft_reset clear all state.
- R11: fault_abort clears all outputs and state on the next edge, even in the middle of a drive. rst_n clears everything asynchronously.
- R12: Profile codes 0, 1, 2 and 3 select the periods PER0, PER1, PER2 and PER3. The code for channel i is prof_sel[2i+1:2i], and it is latched at start.
- R13: hs_drv and ls_drv of a channel are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power reset, active low |
| fault_abort | input | 1 | Ground or reference fault; clears state at once |
| pin_reset | input | 1 | Filtered external reset request |
| soft_reset | input | 1 | Software reset request |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 other, 1 arm, 2 fire, 3 clear success |
| cmd_mask | input | NCH | Channel mask of the command |
| cmd_par_ok | input | 1 | Parity of the command was correct |
| en_grp | input | NCH/2 | Qualified enable for each channel pair |
| prof_sel | input | 2*NCH | Firing profile code for each channel |
| hs_drv | output | NCH | High-side drive for each channel |
| ls_drv | output | NCH | Low-side drive for each channel |
| dep_status | output | NCH | Deployment window or drive in progress |
| dep_success | output | NCH | Sticky deploy-success flag |
| fire_err | output | 1 | Out-of-sequence fire pulse |
| cmd_ignored | output | 1 | Command dropped during a drive |
| diag_stop | output | 1 | Pulse that stops diagnostics on arm |

## Verification
The bound checker tests the following on every cycle:
- the error pulse after an unarmed fire;
- the diagnostics-stop pulse after an arm;
- that drive only occurs inside status;
- that success only falls on a clear or a wipe;
- that a successful channel never starts driving;
- that commands are dropped during a drive;
- the immediate abort on a fault.

Some behaviour only the bench scenarios can show:
- the exact drive length for each profile code;
- the late-enable window and its expiry;
- the pair-to-enable mapping;
- that a reset request is ignored during a drive;
- the AND of the arm and fire masks.

The bench compares all of these, cycle by cycle, against a behavioural model.

// File: rtl/deploy_seq_pkg.sv
package deploy_seq_pkg;
    typedef enum logic [1:0] {
        OP_OTHER = 2'd0,
        OP_ARM   = 2'd1,
        OP_FIRE  = 2'd2,
        OP_CLEAR = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_WAIT  = 2'd1,
        CH_DRIVE = 2'd2
    } ch_state_e;
endpackage

// File: rtl/deploy_cmd_dec.sv
module deploy_cmd_dec
    import deploy_seq_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wipe,
    input  logic           busy,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [NCH-1:0] cmd_mask,
    input  logic           cmd_par_ok,
    output logic           fire_go,
    output logic [NCH-1:0] fire_mask,
    output logic           clr_go,
    output logic           armed,
    output logic           fire_err,
    output logic           cmd_ignored,
    output logic           diag_stop
);
    typedef struct packed {
        logic           armed;
        logic [NCH-1:0] amask;
        logic           err;
        logic           ign;
        logic           diag;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d      = dec_q;
        dec_d.err  = 1'b0;
        dec_d.ign  = 1'b0;
        dec_d.diag = 1'b0;
        fire_go    = 1'b0;
        clr_go     = 1'b0;
        if (wipe) begin
            dec_d.armed = 1'b0;
        end else if (cmd_valid) begin
            if (busy) begin
                dec_d.ign = 1'b1;
            end else begin
                // every accepted command breaks a pending arm
                dec_d.armed = 1'b0;
                if (cmd_par_ok) begin
                    case (cmd_op_e'(cmd_op))
                        OP_ARM: begin
                            dec_d.armed = 1'b1;
                            dec_d.amask = cmd_mask;
                            dec_d.diag  = 1'b1;
                        end
                        OP_FIRE: begin
                            if (dec_q.armed) fire_go = 1'b1;
                            else             dec_d.err = 1'b1;
                        end
                        OP_CLEAR: clr_go = 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign fire_mask   = dec_q.amask & cmd_mask;
    assign armed       = dec_q.armed;
    assign fire_err    = dec_q.err;
    assign cmd_ignored = dec_q.ign;
    assign diag_stop   = dec_q.diag;
endmodule

// File: rtl/deploy_chan.sv
module deploy_chan
    import deploy_seq_pkg::*;
#(
    parameter int unsigned PER0  = 12,
    parameter int unsigned PER1  = 8,
    parameter int unsigned PER2  = 6,
    parameter int unsigned PER3  = 4,
    parameter int unsigned CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wipe,
    input  logic       start,
    input  logic [1:0] prof,
    input  logic       enable,
    input  logic       clr_succ,
    output logic       drive,
    output logic       status,
    output logic       success
);
    typedef struct packed {
        ch_state_e        st;
        logic [1:0]       prof;
        logic [CNT_W-1:0] cnt;
        logic             succ;
    } ch_t;

    ch_t ch_d, ch_q;

    function automatic logic [CNT_W-1:0] period(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(PER0);
            2'd1:    return CNT_W'(PER1);
            2'd2:    return CNT_W'(PER2);
            default: return CNT_W'(PER3);
        endcase
    endfunction

    always_comb begin
        ch_d = ch_q;
        if (wipe) begin
            ch_d = '0;
        end else begin
            case (ch_q.st)
                CH_IDLE: begin
                    if (start && !ch_q.succ) begin
                        ch_d.st   = CH_WAIT;
                        ch_d.prof = prof;
                        ch_d.cnt  = period(prof);
                    end
                end
                CH_WAIT: begin
                    if (enable) begin
                        ch_d.st  = CH_DRIVE;
                        ch_d.cnt = period(ch_q.prof);
                    end else if (ch_q.cnt == CNT_W'(1)) begin
                        ch_d.st = CH_IDLE;
                    end else begin
                        ch_d.cnt = ch_q.cnt - CNT_W'(1);
                    end
                end
                CH_DRIVE: begin
                    if (ch_q.cnt == CNT_W'(1)) begin
                        ch_d.st   = CH_IDLE;
                        ch_d.succ = 1'b1;
                    end else begin
                        ch_d.cnt = ch_q.cnt - CNT_W'(1);
                    end
                end
                default: ch_d.st = CH_IDLE;
            endcase
            if (clr_succ) ch_d.succ = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign drive   = (ch_q.st == CH_DRIVE);
    assign status  = (ch_q.st != CH_IDLE);
    assign success = ch_q.succ;
endmodule

// File: rtl/deploy_seq.sv
module deploy_seq
    import deploy_seq_pkg::*;
#(
    parameter int unsigned NCH  = 8,
    parameter int unsigned PER0 = 12,
    parameter int unsigned PER1 = 8,
    parameter int unsigned PER2 = 6,
    parameter int unsigned PER3 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_abort,
    input  logic             pin_reset,
    input  logic             soft_reset,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [NCH-1:0]   cmd_mask,
    input  logic             cmd_par_ok,
    input  logic [NCH/2-1:0] en_grp,
    input  logic [2*NCH-1:0] prof_sel,
    output logic [NCH-1:0]   hs_drv,
    output logic [NCH-1:0]   ls_drv,
    output logic [NCH-1:0]   dep_status,
    output logic [NCH-1:0]   dep_success,
    output logic             fire_err,
    output logic             cmd_ignored,
    output logic             diag_stop
);
    localparam int unsigned MAX01 = (PER0 > PER1) ? PER0 : PER1;
    localparam int unsigned MAX23 = (PER2 > PER3) ? PER2 : PER3;
    localparam int unsigned PMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned CNT_W = $clog2(PMAX + 1);

    logic           busy;
    logic           wipe;
    logic           fire_go;
    logic           clr_go;
    logic           armed;
    logic [NCH-1:0] fire_mask;
    logic [NCH-1:0] drive;

    assign busy = |drive;
    // reset requests only act while nothing is driving
    assign wipe = fault_abort | ((pin_reset | soft_reset) & ~busy);

    deploy_cmd_dec #(.NCH(NCH)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (wipe),
        .busy       (busy),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_mask   (cmd_mask),
        .cmd_par_ok (cmd_par_ok),
        .fire_go    (fire_go),
        .fire_mask  (fire_mask),
        .clr_go     (clr_go),
        .armed      (armed),
        .fire_err   (fire_err),
        .cmd_ignored(cmd_ignored),
        .diag_stop  (diag_stop)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        deploy_chan #(
            .PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3), .CNT_W(CNT_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wipe    (wipe),
            .start   (fire_go & fire_mask[i]),
            .prof    (prof_sel[2*i +: 2]),
            .enable  (en_grp[i/2]),
            .clr_succ(clr_go & cmd_mask[i]),
            .drive   (drive[i]),
            .status  (dep_status[i]),
            .success (dep_success[i])
        );
    end

    assign hs_drv = drive;
    assign ls_drv = drive;
endmodule

// File: rtl/deploy_seq_chk.sv
module deploy_seq_chk #(
    parameter int unsigned NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fault_abort,
    input logic           cmd_valid,
    input logic [1:0]     cmd_op,
    input logic           cmd_par_ok,
    input logic           armed,
    input logic           busy,
    input logic           wipe,
    input logic [NCH-1:0] hs_drv,
    input logic [NCH-1:0] dep_status,
    input logic [NCH-1:0] dep_success,
    input logic           fire_err,
    input logic           cmd_ignored,
    input logic           diag_stop
);
    // R3
    unarmed_fire_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && cmd_par_ok && !armed && !busy && !wipe) |=> fire_err);

    // R5
    arm_diag_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && cmd_par_ok && !busy && !wipe) |=> diag_stop);

    // R8
    drive_inside_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_drv & ~dep_status) == '0));

    // R8
    success_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_valid && cmd_op == 2'd3) && !wipe) |=> ((~dep_success & $past(dep_success)) == '0));

    // R9
    no_redeploy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_drv & ~$past(hs_drv) & $past(dep_success)) == '0));

    // R10
    busy_cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (|hs_drv) && !fault_abort) |=> cmd_ignored);

    // R11
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_abort |=> (hs_drv == '0 && dep_status == '0 && dep_success == '0));
endmodule

bind deploy_seq deploy_seq_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_abort(fault_abort),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_par_ok (cmd_par_ok),
    .armed      (armed),
    .busy       (busy),
    .wipe       (wipe),
    .hs_drv     (hs_drv),
    .dep_status (dep_status),
    .dep_success(dep_success),
    .fire_err   (fire_err),
    .cmd_ignored(cmd_ignored),
    .diag_stop  (diag_stop)
);

// File: tb/deploy_seq_tb.sv
module deploy_seq_tb_top;
    localparam int P0 = 12, P1 = 8, P2 = 6, P3 = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_abort = 1'b0, pin_reset = 1'b0, soft_reset = 1'b0;
    logic        cmd_valid = 1'b0, cmd_par_ok = 1'b1;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_mask = 8'h00;
    logic [3:0]  en_grp = 4'h0;
    logic [15:0] prof_sel = 16'hE4E4;
    logic [7:0]  hs_drv, ls_drv, dep_status, dep_success;
    logic        fire_err, cmd_ignored, diag_stop;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    deploy_seq #(.NCH(8), .PER0(P0), .PER1(P1), .PER2(P2), .PER3(P3)) dut_i (
        .clk(clk), .rst_n(rst_n), .fault_abort(fault_abort), .pin_reset(pin_reset),
        .soft_reset(soft_reset), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .cmd_par_ok(cmd_par_ok), .en_grp(en_grp),
        .prof_sel(prof_sel), .hs_drv(hs_drv), .ls_drv(ls_drv),
        .dep_status(dep_status), .dep_success(dep_success), .fire_err(fire_err),
        .cmd_ignored(cmd_ignored), .diag_stop(diag_stop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 waiting for enable, 2 driving
    int  m_st[8], m_cnt[8], m_prof[8];
    bit  m_succ[8];
    bit  m_armed, m_err, m_ign, m_diag;
    logic [7:0] m_amask;

    function automatic int per_of(input int c);
        case (c)
            0: return P0;
            1: return P1;
            2: return P2;
            default: return P3;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_st[i] = 0; m_cnt[i] = 0; m_prof[i] = 0; m_succ[i] = 0;
            end
            m_armed = 0; m_err = 0; m_ign = 0; m_diag = 0; m_amask = 0;
        end else begin
            bit busy_m, go, clr;
            logic [7:0] fm;
            busy_m = 0; go = 0; clr = 0; fm = 0;
            for (int i = 0; i < 8; i++) if (m_st[i] == 2) busy_m = 1;
            m_err = 0; m_ign = 0; m_diag = 0;
            if (fault_abort || ((pin_reset || soft_reset) && !busy_m)) begin
                for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_cnt[i] = 0; m_succ[i] = 0; end
                m_armed = 0;
            end else begin
                if (cmd_valid) begin
                    if (busy_m) m_ign = 1;
                    else begin
                        bit was_armed;
                        was_armed = m_armed;
                        m_armed = 0;
                        if (cmd_par_ok) begin
                            if (cmd_op == 2'd1) begin m_armed = 1; m_amask = cmd_mask; m_diag = 1; end
                            else if (cmd_op == 2'd2) begin
                                if (was_armed) begin go = 1; fm = m_amask & cmd_mask; end
                                else m_err = 1;
                            end else if (cmd_op == 2'd3) clr = 1;
                        end
                    end
                end
                for (int i = 0; i < 8; i++) begin
                    if (m_st[i] == 0) begin
                        if (go && fm[i] && !m_succ[i]) begin
                            m_st[i] = 1; m_prof[i] = int'(prof_sel[2*i +: 2]); m_cnt[i] = per_of(m_prof[i]);
                        end
                    end else if (m_st[i] == 1) begin
                        if (en_grp[i/2]) begin m_st[i] = 2; m_cnt[i] = per_of(m_prof[i]); end
                        else if (m_cnt[i] == 1) m_st[i] = 0;
                        else m_cnt[i]--;
                    end else begin
                        if (m_cnt[i] == 1) begin m_st[i] = 0; m_succ[i] = 1; end
                        else m_cnt[i]--;
                    end
                    if (clr && cmd_mask[i]) m_succ[i] = 0;
                end
            end
        end
    end

    int drv_len[8];

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e_drv, e_st, e_sc;
            for (int i = 0; i < 8; i++) begin
                e_drv[i] = (m_st[i] == 2);
                e_st[i]  = (m_st[i] != 0);
                e_sc[i]  = m_succ[i];
                if (hs_drv[i]) drv_len[i]++;
            end
            chk("R6 drive vs model", 32'(hs_drv), 32'(e_drv));
            chk("R13 low side equals high side", 32'(ls_drv), 32'(hs_drv));
            chk("R8 status vs model", 32'(dep_status), 32'(e_st));
            chk("R8 success vs model", 32'(dep_success), 32'(e_sc));
            chk("R3 fire_err vs model", 32'(fire_err), 32'(m_err));
            chk("R10 cmd_ignored vs model", 32'(cmd_ignored), 32'(m_ign));
            chk("R5 diag_stop vs model", 32'(diag_stop), 32'(m_diag));
        end
    end

    task automatic send(input logic [1:0] op, input logic [7:0] m, input logic par);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mask = m; cmd_par_ok = par;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0; cmd_mask = 8'h00; cmd_par_ok = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clr_len();
        for (int i = 0; i < 8; i++) drv_len[i] = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) drv_len[i] = 0;
        wait_cyc(3);
        chk("R11 reset outputs", 32'({hs_drv, dep_status, dep_success}), 32'h0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 R12: AND of masks, per-profile period
        en_grp = 4'hF; clr_len();
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd1; cmd_mask = 8'h0F;
        @(negedge clk); chk("R5 diag_stop after arm", 32'(diag_stop), 32'h1);
        cmd_op = 2'd2; cmd_mask = 8'h05;
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'd0; cmd_mask = 8'h00;
        chk("R1 status of AND mask", 32'(dep_status), 32'h05);
        wait_cyc(40);
        chk("R12 ch0 code0 length", 32'(drv_len[0]), 32'(P0));
        chk("R12 ch2 code2 length", 32'(drv_len[2]), 32'(P2));
        chk("R1 ch1 not in fire mask", 32'(drv_len[1]), 32'h0);
        chk("R8 success after drive", 32'(dep_success), 32'h05);

        // R9 inhibit, R8 clear
        clr_len();
        send(2'd1, 8'h01, 1'b1); send(2'd2, 8'h01, 1'b1);
        wait_cyc(30);
        chk("R9 no redeploy while success", 32'(drv_len[0]), 32'h0);
        send(2'd3, 8'h01, 1'b1);
        chk("R8 clear by mask", 32'(dep_success), 32'h04);
        send(2'd3, 8'hFF, 1'b1);

        // R2 R3: broken sequence
        send(2'd1, 8'hFF, 1'b1); send(2'd0, 8'h00, 1'b1); send(2'd2, 8'hFF, 1'b1);
        chk("R3 fire_err after broken sequence", 32'(fire_err), 32'h1);
        wait_cyc(3);
        chk("R2 nothing started", 32'(dep_status), 32'h0);

        // R4 parity
        send(2'd1, 8'hFF, 1'b0); send(2'd2, 8'hFF, 1'b1);
        chk("R4 bad arm discarded", 32'(fire_err), 32'h1);
        send(2'd1, 8'hFF, 1'b1); send(2'd2, 8'hFF, 1'b0);
        chk("R4 bad fire no error", 32'(fire_err), 32'h0);
        wait_cyc(3);
        chk("R4 bad fire no start", 32'(dep_status), 32'h0);
        send(2'd2, 8'hFF, 1'b1);
        chk("R4 arm cancelled by bad fire", 32'(fire_err), 32'h1);

        // R6 R7: window expiry and late enable
        en_grp = 4'b1011; clr_len();
        send(2'd1, 8'h10, 1'b1); send(2'd2, 8'h10, 1'b1);
        wait_cyc(2);
        chk("R6 waiting without drive", 32'({dep_status[4], hs_drv[4]}), 32'h2);
        wait_cyc(20);
        chk("R6 window expired", 32'({dep_status[4], dep_success[4]}), 32'h0);
        chk("R7 other enables ignored", 32'(drv_len[4]), 32'h0);
        send(2'd1, 8'h10, 1'b1); send(2'd2, 8'h10, 1'b1);
        wait_cyc(5); en_grp = 4'hF;
        wait_cyc(20);
        chk("R6 late enable full period", 32'(drv_len[4]), 32'(P0));
        chk("R7 group 2 enabled ch4", 32'(dep_success[4]), 32'h1);
        send(2'd3, 8'hFF, 1'b1);

        // R10: ignored during drive
        clr_len();
        send(2'd1, 8'h30, 1'b1); send(2'd2, 8'h30, 1'b1);
        wait_cyc(3);
        en_grp = 4'h0;
        @(negedge clk); pin_reset = 1'b1; soft_reset = 1'b1;
        @(negedge clk); pin_reset = 1'b0; soft_reset = 1'b0;
        send(2'd3, 8'hFF, 1'b1);
        chk("R10 command ignored", 32'(cmd_ignored), 32'h1);
        wait_cyc(20);
        chk("R10 drive kept length", 32'(drv_len[4]), 32'(P0));
        chk("R10 success despite resets", 32'(dep_success), 32'h30);

        // R10 reset when idle, R11 abort
        @(negedge clk); soft_reset = 1'b1;
        @(negedge clk); soft_reset = 1'b0;
        chk("R10 soft reset when idle", 32'(dep_success), 32'h0);
        en_grp = 4'hF;
        send(2'd1, 8'h01, 1'b1); send(2'd2, 8'h01, 1'b1);
        wait_cyc(3);
        chk("R11 driving before abort", 32'(hs_drv[0]), 32'h1);
        @(negedge clk); fault_abort = 1'b1;
        @(negedge clk); fault_abort = 1'b0;
        chk("R11 abort clears drive", 32'({hs_drv, dep_status, dep_success}), 32'h0);
        wait_cyc(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule